// File: doc/BRIEF.md
# FIFO Fill-Level Interrupt Status Generator

This block turns the fill counts of a serial port's receive and transmit FIFOs (256 entries each by default) into two registered interrupt-status bits. Each bit feeds an interrupt arbiter directly. A separately enabled copy of each bit goes to a DMA handshake. The FIFO storage, its counters and the serial data path sit outside the block. The block sees the registered fill counts and the push and pop strobes of the current cycle. It computes the fill level that will hold after the coming edge and registers the status at that same edge, so the status bits always match the fill counts presented to it.

The receive bit has four trigger settings. The first asserts as soon as any character is waiting. The second asserts only when a transfer fills the FIFO completely, including the transfer of a character that was held back in the shift register while the FIFO was full. The other two compare the fill level against half and three quarters of the depth. The transmit bit has inverted polarity: it asserts as the FIFO drains. Its trigger settings are "completely empty", "below three quarters", "below half" and "not full".

Top module: `fifo_irq_status`

## Requirements
- R1: During synchronous active-low reset and in the first cycle after it, rx_int is 0, tx_int is 1 and both DMA requests follow those values.
- R2: With rx_trig_sel = 2'b00, rx_int becomes 1 at the edge where a push leaves at least one character in the receive FIFO, and it stays 1 until the edge where a pop removes the last character.
- R3: With rx_trig_sel = 2'b01, rx_int becomes 1 at the edge where a push makes the receive FIFO full (DEPTH entries). It is 0 at every edge after which the FIFO is not full.
- R4: With rx_trig_sel = 2'b01, a push tagged with rx_held = 1 that refills the FIFO after a pop sets rx_int again. rx_held asserted without a push changes nothing.
- R5: rx_trig_sel = 2'b10 makes rx_int equal to (fill >= DEPTH/2). rx_trig_sel = 2'b11 makes it equal to (fill >= 3*DEPTH/4).
- R6: rx_int is 0 whenever the receive fill count is 0, in every mode.
- R7: With tx_trig_sel = 2'b00, tx_int is 1 only while the transmit fill count is 0.
- R8: tx_trig_sel = 2'b01, 2'b10 and 2'b11 make tx_int equal to fill < 3*DEPTH/4, fill < DEPTH/2 and fill < DEPTH respectively. The bit drops as the FIFO fills past the level and returns as it drains below it.
- R9: tx_int is 0 whenever the transmit fill count equals DEPTH, in every mode.
- R10: The status bits are registered. A push, pop or trigger-select change in cycle n shows on rx_int and tx_int only after the clock edge that ends cycle n.
- R11: rx_dma_req equals rx_int AND rx_dma_en, and tx_dma_req equals tx_int AND tx_dma_en. Both are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_fill | input | 9 | Current receive FIFO fill count (0..DEPTH) |
| rx_push | input | 1 | A character enters the receive FIFO this cycle |
| rx_pop | input | 1 | The host reads a character this cycle |
| rx_held | input | 1 | The character in the shift register was held back by a full FIFO |
| rx_trig_sel | input | 2 | Receive trigger select |
| tx_fill | input | 9 | Current transmit FIFO fill count (0..DEPTH) |
| tx_push | input | 1 | The host writes a character this cycle |
| tx_pop | input | 1 | The transmitter takes a character this cycle |
| tx_trig_sel | input | 2 | Transmit trigger select |
| rx_dma_en | input | 1 | Enables the receive DMA request |
| tx_dma_en | input | 1 | Enables the transmit DMA request |
| rx_int | output | 1 | Receive interrupt status |
| tx_int | output | 1 | Transmit interrupt status |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |

## Verification
On every cycle, the assertions check the level-defined behaviours against the fill counts: the empty and full blocking rules, ready mode, the threshold modes of both directions, the rule that full mode only reports a full FIFO, and DMA gating. The event-driven full-mode behaviour is different. Setting only on the filling transfer, re-setting when the held character lands, and ignoring a lone held flag all depend on the history of pushes and pops, so only the bench's scenarios show them. The bench's scenarios are also the only evidence for the one-edge latency and for reset.

// File: rtl/fifo_irq_pkg.sv
// Package: shared trigger-select encodings for the FIFO interrupt status block.
// Assumes the two-bit select fields are decoded exactly as listed here.
package fifo_irq_pkg;

    typedef enum logic [1:0] {
        RXM_READY = 2'b00,   // any character waiting
        RXM_FULL  = 2'b01,   // event-driven, FIFO completely full
        RXM_HALF  = 2'b10,   // fill >= DEPTH/2
        RXM_3Q    = 2'b11    // fill >= 3*DEPTH/4
    } rx_mode_e;

    typedef enum logic [1:0] {
        TXM_EMPTY = 2'b00,   // fill == 0
        TXM_3Q    = 2'b01,   // fill < 3*DEPTH/4
        TXM_HALF  = 2'b10,   // fill < DEPTH/2
        TXM_ROOM  = 2'b11    // fill < DEPTH
    } tx_mode_e;

endpackage

// File: rtl/fill_next.sv
// Module: fill_next
// Predicts the FIFO fill count that will hold after the coming clock edge.
// Assumes the FIFO never pushes when full nor pops when empty.
module fill_next #(
    parameter int CW = 9
) (
    input  logic [CW-1:0] fill,
    input  logic          push,
    input  logic          pop,
    output logic [CW-1:0] fill_nxt
);

    // Add the push and subtract the pop of this cycle.
    always_comb begin
        fill_nxt = fill + CW'(push) - CW'(pop);
    end

endmodule

// File: rtl/rx_irq_unit.sv
// Module: rx_irq_unit
// Registers the receive interrupt-status bit according to the selected mode.
// Assumes fill_nxt is the receive fill count that holds after the coming edge.
module rx_irq_unit
    import fifo_irq_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int CW    = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] fill_nxt,
    input  logic          push,
    input  logic          held,
    input  logic [1:0]    sel,
    output logic          irq
);

    localparam logic [CW-1:0] LVL_FULL = CW'(DEPTH);
    localparam logic [CW-1:0] LVL_HALF = CW'(DEPTH / 2);
    localparam logic [CW-1:0] LVL_3Q   = CW'((DEPTH * 3) / 4);

    logic     nxt_empty;
    logic     nxt_full;
    logic     fresh_fill;
    logic     held_fill;
    logic     irq_d;
    rx_mode_e mode;

    // Decode the mode and the fill events of this cycle.
    always_comb begin
        mode       = rx_mode_e'(sel);
        nxt_empty  = (fill_nxt == '0);
        nxt_full   = (fill_nxt == LVL_FULL);
        fresh_fill = push & !held & nxt_full;
        held_fill  = push & held & nxt_full;
    end

    // Choose the next status value from the mode rule.
    always_comb begin
        unique case (mode)
            RXM_READY: irq_d = !nxt_empty;
            RXM_FULL: begin
                if (fresh_fill || held_fill) irq_d = 1'b1;
                else if (!nxt_full)          irq_d = 1'b0;
                else                         irq_d = irq;
            end
            RXM_HALF:  irq_d = (fill_nxt >= LVL_HALF);
            default:   irq_d = (fill_nxt >= LVL_3Q);
        endcase
        if (nxt_empty) irq_d = 1'b0;
    end

    // Status register; reset means the receive FIFO is empty.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= irq_d;
    end

endmodule

// File: rtl/tx_irq_unit.sv
// Module: tx_irq_unit
// Registers the transmit interrupt-status bit; asserts while the FIFO is below its level.
// Assumes fill_nxt is the transmit fill count that holds after the coming edge.
module tx_irq_unit
    import fifo_irq_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int CW    = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] fill_nxt,
    input  logic [1:0]    sel,
    output logic          irq
);

    localparam logic [CW-1:0] LVL_FULL = CW'(DEPTH);
    localparam logic [CW-1:0] LVL_HALF = CW'(DEPTH / 2);
    localparam logic [CW-1:0] LVL_3Q   = CW'((DEPTH * 3) / 4);

    logic [CW-1:0] limit;
    logic          irq_d;

    // Pick the "fewer than" limit for the selected mode.
    always_comb begin
        unique case (tx_mode_e'(sel))
            TXM_EMPTY: limit = CW'(1);
            TXM_3Q:    limit = LVL_3Q;
            TXM_HALF:  limit = LVL_HALF;
            default:   limit = LVL_FULL;
        endcase
        irq_d = (fill_nxt < limit) && (fill_nxt != LVL_FULL);
    end

    // Status register; reset means the transmit FIFO is empty.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b1;
        else        irq <= irq_d;
    end

endmodule

// File: rtl/fifo_irq_status.sv
// Module: fifo_irq_status (top)
// Generates the receive and transmit interrupt-status bits and the gated DMA requests
// from the FIFO fill counts and strobes. Assumes rx_fill and tx_fill are the registered
// FIFO counts and that the strobes update them at the same edge this block samples.
module fifo_irq_status #(
    parameter int DEPTH = 256,
    parameter int CW    = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] rx_fill,
    input  logic          rx_push,
    input  logic          rx_pop,
    input  logic          rx_held,
    input  logic [1:0]    rx_trig_sel,
    input  logic [CW-1:0] tx_fill,
    input  logic          tx_push,
    input  logic          tx_pop,
    input  logic [1:0]    tx_trig_sel,
    input  logic          rx_dma_en,
    input  logic          tx_dma_en,
    output logic          rx_int,
    output logic          tx_int,
    output logic          rx_dma_req,
    output logic          tx_dma_req
);

    logic [CW-1:0] rx_fill_nxt;
    logic [CW-1:0] tx_fill_nxt;

    fill_next #(.CW(CW)) rx_nxt_i (
        .fill     (rx_fill),
        .push     (rx_push),
        .pop      (rx_pop),
        .fill_nxt (rx_fill_nxt)
    );

    fill_next #(.CW(CW)) tx_nxt_i (
        .fill     (tx_fill),
        .push     (tx_push),
        .pop      (tx_pop),
        .fill_nxt (tx_fill_nxt)
    );

    rx_irq_unit #(.DEPTH(DEPTH), .CW(CW)) rx_unit_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .fill_nxt (rx_fill_nxt),
        .push     (rx_push),
        .held     (rx_held),
        .sel      (rx_trig_sel),
        .irq      (rx_int)
    );

    tx_irq_unit #(.DEPTH(DEPTH), .CW(CW)) tx_unit_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .fill_nxt (tx_fill_nxt),
        .sel      (tx_trig_sel),
        .irq      (tx_int)
    );

    // Gate the status bits onto the DMA handshake lines.
    always_comb begin
        rx_dma_req = rx_int & rx_dma_en;
        tx_dma_req = tx_int & tx_dma_en;
    end

endmodule

// File: rtl/fifo_irq_status_chk.sv
// Module: fifo_irq_status_chk
// Checker bound to fifo_irq_status; relates the status bits to the fill counts.
// Assumes the fill counts follow the strobes as a real FIFO's would.
module fifo_irq_status_chk #(
    parameter int DEPTH = 256,
    parameter int CW    = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] rx_fill,
    input logic [1:0]    rx_trig_sel,
    input logic [CW-1:0] tx_fill,
    input logic [1:0]    tx_trig_sel,
    input logic          rx_dma_en,
    input logic          tx_dma_en,
    input logic          rx_int,
    input logic          tx_int,
    input logic          rx_dma_req,
    input logic          tx_dma_req
);

    localparam logic [CW-1:0] C_FULL = CW'(DEPTH);
    localparam logic [CW-1:0] C_HALF = CW'(DEPTH / 2);
    localparam logic [CW-1:0] C_3Q   = CW'((DEPTH * 3) / 4);

    AST_RX_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_fill == '0) |-> !rx_int); // R6
    AST_TX_FULL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_fill == C_FULL) |-> !tx_int); // R9
    AST_RX_READY_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rx_trig_sel) == 2'b00) |-> (rx_int == (rx_fill != '0))); // R2
    AST_RX_FULL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rx_trig_sel) == 2'b01 && rx_int) |-> (rx_fill == C_FULL)); // R3
    AST_RX_HALF_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rx_trig_sel) == 2'b10) |-> (rx_int == (rx_fill >= C_HALF))); // R5
    AST_RX_3Q_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rx_trig_sel) == 2'b11) |-> (rx_int == (rx_fill >= C_3Q))); // R5
    AST_TX_EMPTY_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tx_trig_sel) == 2'b00) |-> (tx_int == (tx_fill == '0))); // R7
    AST_TX_3Q_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tx_trig_sel) == 2'b01) |-> (tx_int == (tx_fill < C_3Q))); // R8
    AST_TX_HALF_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tx_trig_sel) == 2'b10) |-> (tx_int == (tx_fill < C_HALF))); // R8
    AST_RX_DMA_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dma_req |-> (rx_int && rx_dma_en)); // R11
    AST_TX_DMA_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        tx_dma_req |-> (tx_int && tx_dma_en)); // R11

endmodule

bind fifo_irq_status fifo_irq_status_chk #(.DEPTH(DEPTH), .CW(CW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_fill     (rx_fill),
    .rx_trig_sel (rx_trig_sel),
    .tx_fill     (tx_fill),
    .tx_trig_sel (tx_trig_sel),
    .rx_dma_en   (rx_dma_en),
    .tx_dma_en   (tx_dma_en),
    .rx_int      (rx_int),
    .tx_int      (tx_int),
    .rx_dma_req  (rx_dma_req),
    .tx_dma_req  (tx_dma_req)
);

// File: tb/fifo_irq_status_tb_top.sv
`timescale 1ns/100ps
// Bench for fifo_irq_status: a vector table walked by one loop, then directed tests.
// The bench owns the FIFO fill counts and updates them after each edge.
module fifo_irq_status_tb_top;

    localparam int DEPTH = 256;
    localparam int CW    = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] rx_fill = '0;
    logic          rx_push = 1'b0;
    logic          rx_pop = 1'b0;
    logic          rx_held = 1'b0;
    logic [1:0]    rx_trig_sel = 2'b00;
    logic [CW-1:0] tx_fill = '0;
    logic          tx_push = 1'b0;
    logic          tx_pop = 1'b0;
    logic [1:0]    tx_trig_sel = 2'b00;
    logic          rx_dma_en = 1'b0;
    logic          tx_dma_en = 1'b0;
    logic          rx_int;
    logic          tx_int;
    logic          rx_dma_req;
    logic          tx_dma_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    fifo_irq_status #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .rx_fill(rx_fill), .rx_push(rx_push), .rx_pop(rx_pop), .rx_held(rx_held),
        .rx_trig_sel(rx_trig_sel),
        .tx_fill(tx_fill), .tx_push(tx_push), .tx_pop(tx_pop), .tx_trig_sel(tx_trig_sel),
        .rx_dma_en(rx_dma_en), .tx_dma_en(tx_dma_en),
        .rx_int(rx_int), .tx_int(tx_int), .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req)
    );

    // Actions: 0 idle, 1 rx push, 2 rx pop, 3 tx push, 4 tx pop,
    // 5 rx push of the held character, 6 held flag without push.
    typedef struct packed {
        logic [1:0] rs;
        logic [1:0] ts;
        logic [2:0] act;
        logic [8:0] n;
        logic       er;
        logic       et;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 33;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 2'd0, 3'd0, 9'd1,   1'b0, 1'b1, 4'd1},  // R1 idle after reset
        '{2'd0, 2'd0, 3'd1, 9'd1,   1'b1, 1'b1, 4'd2},  // R2 rx=1
        '{2'd0, 2'd0, 3'd2, 9'd1,   1'b0, 1'b1, 4'd2},  // R2 rx=0 last read
        '{2'd0, 2'd0, 3'd1, 9'd3,   1'b1, 1'b1, 4'd2},  // R2 rx=3
        '{2'd0, 2'd0, 3'd2, 9'd2,   1'b1, 1'b1, 4'd2},  // R2 rx=1 still set
        '{2'd0, 2'd0, 3'd2, 9'd1,   1'b0, 1'b1, 4'd6},  // R6 rx=0
        '{2'd2, 2'd0, 3'd1, 9'd127, 1'b0, 1'b1, 4'd5},  // R5 rx=127
        '{2'd2, 2'd0, 3'd1, 9'd1,   1'b1, 1'b1, 4'd5},  // R5 rx=128
        '{2'd2, 2'd0, 3'd2, 9'd1,   1'b0, 1'b1, 4'd5},  // R5 rx=127
        '{2'd3, 2'd0, 3'd1, 9'd65,  1'b1, 1'b1, 4'd5},  // R5 rx=192
        '{2'd3, 2'd0, 3'd2, 9'd1,   1'b0, 1'b1, 4'd5},  // R5 rx=191
        '{2'd1, 2'd0, 3'd1, 9'd64,  1'b0, 1'b1, 4'd3},  // R3 rx=255
        '{2'd1, 2'd0, 3'd1, 9'd1,   1'b1, 1'b1, 4'd3},  // R3 rx=256
        '{2'd1, 2'd0, 3'd2, 9'd1,   1'b0, 1'b1, 4'd3},  // R3 rx=255
        '{2'd1, 2'd0, 3'd5, 9'd1,   1'b1, 1'b1, 4'd4},  // R4 held lands, 256
        '{2'd1, 2'd0, 3'd2, 9'd1,   1'b0, 1'b1, 4'd4},  // R4 rx=255
        '{2'd1, 2'd0, 3'd6, 9'd3,   1'b0, 1'b1, 4'd4},  // R4 held alone, no effect
        '{2'd1, 2'd0, 3'd5, 9'd1,   1'b1, 1'b1, 4'd4},  // R4 rx=256
        '{2'd2, 2'd0, 3'd0, 9'd1,   1'b1, 1'b1, 4'd5},  // R5 rx=256 half mode
        '{2'd2, 2'd0, 3'd2, 9'd256, 1'b0, 1'b1, 4'd6},  // R6 drained
        '{2'd0, 2'd0, 3'd3, 9'd1,   1'b0, 1'b0, 4'd7},  // R7 tx=1
        '{2'd0, 2'd0, 3'd4, 9'd1,   1'b0, 1'b1, 4'd7},  // R7 tx=0
        '{2'd0, 2'd1, 3'd3, 9'd191, 1'b0, 1'b1, 4'd8},  // R8 tx=191
        '{2'd0, 2'd1, 3'd3, 9'd1,   1'b0, 1'b0, 4'd8},  // R8 tx=192
        '{2'd0, 2'd1, 3'd4, 9'd1,   1'b0, 1'b1, 4'd8},  // R8 tx=191
        '{2'd0, 2'd2, 3'd0, 9'd1,   1'b0, 1'b0, 4'd8},  // R8 half mode at 191
        '{2'd0, 2'd2, 3'd4, 9'd63,  1'b0, 1'b0, 4'd8},  // R8 tx=128
        '{2'd0, 2'd2, 3'd4, 9'd1,   1'b0, 1'b1, 4'd8},  // R8 tx=127
        '{2'd0, 2'd3, 3'd3, 9'd128, 1'b0, 1'b1, 4'd8},  // R8 tx=255
        '{2'd0, 2'd3, 3'd3, 9'd1,   1'b0, 1'b0, 4'd9},  // R9 tx=256
        '{2'd0, 2'd3, 3'd4, 9'd1,   1'b0, 1'b1, 4'd8},  // R8 tx=255
        '{2'd0, 2'd0, 3'd0, 9'd1,   1'b0, 1'b0, 4'd7},  // R7 empty mode at 255
        '{2'd0, 2'd0, 3'd4, 9'd255, 1'b0, 1'b1, 4'd7}   // R7 tx=0
    };

    // Compare one value and report a failure line.
    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // One clock of strobes; the fill counts follow just after the edge.
    task automatic step(input logic rp, input logic rpo, input logic rh,
                        input logic tp, input logic tpo);
        @(negedge clk);
        rx_push = rp; rx_pop = rpo; rx_held = rh; tx_push = tp; tx_pop = tpo;
        @(posedge clk);
        #1;
        rx_fill = rx_fill + CW'(rp) - CW'(rpo);
        tx_fill = tx_fill + CW'(tp) - CW'(tpo);
        rx_push = 1'b0; rx_pop = 1'b0; rx_held = 1'b0; tx_push = 1'b0; tx_pop = 1'b0;
    endtask

    // Print the single summary line.
    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    // Main stimulus.
    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", "rx_int in reset", rx_int, 1'b0);
        check("R1", "tx_int in reset", tx_int, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", VEC[i].rq);
            rx_trig_sel = VEC[i].rs;
            tx_trig_sel = VEC[i].ts;
            for (int k = 0; k < int'(VEC[i].n); k++) begin
                unique case (VEC[i].act)
                    3'd1:    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
                    3'd2:    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
                    3'd3:    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
                    3'd4:    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
                    3'd5:    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
                    3'd6:    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
                    default: step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
                endcase
            end
            @(negedge clk);
            check(tag, $sformatf("rx_int vec %0d", i), rx_int, VEC[i].er);
            check(tag, $sformatf("tx_int vec %0d", i), tx_int, VEC[i].et);
        end

        // R10: a push is invisible before the edge and visible after it.
        rx_trig_sel = 2'b00;
        @(negedge clk);
        rx_push = 1'b1;
        #1;
        check("R10", "rx_int before edge", rx_int, 1'b0);
        @(posedge clk);
        #1;
        rx_fill = rx_fill + 1'b1;
        rx_push = 1'b0;
        @(negedge clk);
        check("R10", "rx_int after edge", rx_int, 1'b1);
        // R10: a select change takes effect only at the next edge (tx fill 0, mode 2'b01 -> 1).
        tx_trig_sel = 2'b01;
        #1;
        check("R10", "tx_int on select change", tx_int, 1'b1);

        // R11: DMA requests follow the enables (rx_int=1, tx_int=1 here).
        rx_dma_en = 1'b0; tx_dma_en = 1'b0;
        #1;
        check("R11", "rx_dma_req disabled", rx_dma_req, 1'b0);
        check("R11", "tx_dma_req disabled", tx_dma_req, 1'b0);
        rx_dma_en = 1'b1;
        #1;
        check("R11", "rx_dma_req enabled", rx_dma_req, 1'b1);
        check("R11", "tx_dma_req still off", tx_dma_req, 1'b0);
        tx_dma_en = 1'b1;
        #1;
        check("R11", "tx_dma_req enabled", tx_dma_req, 1'b1);

        // R9/R11: fill transmit FIFO in mode 2'b11; tx_int and its request drop at full.
        tx_trig_sel = 2'b11;
        for (int k = 0; k < DEPTH; k++) step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        check("R9", "tx_int full", tx_int, 1'b0);
        check("R11", "tx_dma_req full", tx_dma_req, 1'b0);

        // R1: reset mid-run restores rx_int=0 and tx_int=1.
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        rx_fill = '0;
        tx_fill = '0;
        @(negedge clk);
        check("R1", "rx_int after reset", rx_int, 1'b0);
        check("R1", "tx_int after reset", tx_int, 1'b1);
        check("R1", "tx_dma_req after reset", tx_dma_req, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "tx_int first cycle", tx_int, 1'b1);

        finish_run();
    end

endmodule